// File: doc/BRIEF.md
# Packet Loader Engine

This block takes over the shared receive byte stream once a command responder has accepted either a download command or a start command. In a download session it collects a four-byte packet header and its check byte, then a length byte, the data bytes and a closing check byte. It holds the data in a local 256-entry buffer and copies the buffer to a byte-wide memory write port only after the data check byte has matched. Each packet lands at the packet index times 256, so packets fill the target space in fixed 256-byte slots.

In a start session it collects a four-byte address and its check byte. The all-ones address closes off the preceding download and raises a finalise pulse. Any other address inside an inclusive window set by parameters raises a jump request that carries the address. Each session ends with a one-cycle `done` pulse, together with a single reply byte on the transmit stream. A session that times out ends with no reply. The command responder sends the reply byte and returns to command parsing when it sees `done`.

Top module: `pkt_load_engine`

## Requirements
- R1: After reset, `tx_valid`, `done`, `mem_we`, `fin_pulse` and `jump_req` are all low, and the engine waits for a go pulse.
- R2: The download header consists of an operation byte, a 24-bit packet index sent most significant byte first, and a check byte. The check byte makes the XOR of all five bytes zero. The engine accepts operation 0x00 (normal) and the special operations 0xF2 and 0xF4 by driving `tx_valid` with `tx_data` = 0x79 in the cycle after the check byte. For the special operations `mem_special` is high on every write.
- R3: A reserved operation (0xF3 or any value other than 0x00, 0xF2 or 0xF4), or a header check byte that does not match, produces `tx_data` = 0x1F together with `done`. No memory write follows.
- R4: The length byte L announces L+1 data bytes. The data check byte must make the XOR of L, all data bytes and the check byte zero. On a mismatch the engine replies 0x1F with `done` and performs no memory write.
- R5: When the data check matches, L+1 writes follow in consecutive cycles, starting in the cycle after the check byte. They use addresses index×256+0 up to index×256+L in ascending order and carry the data bytes in arrival order.
- R6: The 0x79 reply and `done` appear in the cycle after the last write.
- R7: The start payload is a four-byte address sent most significant byte first, followed by its XOR check byte. The address 0xFFFFFFFF gives `fin_pulse`, a 0x79 reply and no jump request.
- R8: A start address inside the inclusive window 0x10000000 to 0x1FFFFFFF (default parameters) gives `jump_req`, `jump_addr` equal to the address, and a 0x79 reply. An address outside the window, or a check byte that does not match, gives a 0x1F reply and no jump request.
- R9: If no byte arrives for TMO_CYC consecutive cycles while the engine waits, it ends the session with `done` and without a reply byte or a memory write. A byte that arrives in the last cycle of that window is still accepted.
- R10: Go pulses during a session, and bytes that arrive while no session is open, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go_dl | input | 1 | Opens a download session (one cycle) |
| go_st | input | 1 | Opens a start session (one cycle) |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Reply byte present this cycle |
| tx_data | output | 8 | Reply byte, 0x79 accept or 0x1F refuse |
| done | output | 1 | Session finished (one cycle) |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_special | output | 1 | Write belongs to a special operation |
| fin_pulse | output | 1 | Download finalise request (one cycle) |
| jump_req | output | 1 | Jump request (one cycle) |
| jump_addr | output | 32 | Jump target, valid with jump_req |

## Verification
Two events can fall in the same cycle: expiry of the byte timer and the arrival of a host byte. In that case the byte must win and the count must restart. The bench sends a full download in which one gap lasts exactly TMO_CYC-1 idle cycles, so the next byte lands in the final cycle of the window, and it expects normal writes and a 0x79 reply. It then repeats the session with a gap one cycle longer and expects a silent `done` with no writes. This pins the boundary to a single cycle on each side.

// File: rtl/pl_pkg.sv
// Shared constants and types for the packet loader engine.
// Assumes 8-bit protocol bytes and 256-byte packet slots.
package pl_pkg;
    localparam int PKT_SHIFT = 8;                 // log2 of packet slot size
    localparam int IDX_W     = 24;                // packet index width
    localparam int MA_W      = IDX_W + PKT_SHIFT; // memory address width
    localparam logic [7:0] REPLY_ACK  = 8'h79;
    localparam logic [7:0] REPLY_NACK = 8'h1F;

    typedef enum logic [3:0] {
        S_IDLE, S_HDR, S_HCK, S_LEN, S_DATA, S_DCK, S_WRITE, S_SADR, S_SCK
    } pl_state_t;

    // True for the operation codes that may be accepted.
    function automatic logic op_allowed(input logic [7:0] op);
        return (op == 8'h00) || (op == 8'hF2) || (op == 8'hF4);
    endfunction
endpackage

// File: rtl/pl_timer.sv
// Byte wait timer. Counts cycles spent waiting with no byte and flags
// expiry on the last cycle of the window when no byte arrives then.
// Assumes TMO_CYC >= 2.
module pl_timer #(
    parameter int TMO_CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic waiting,
    input  logic rx_valid,
    output logic expire
);
    localparam int CW = $clog2(TMO_CYC + 1);
    logic [CW-1:0] cnt_q;

    // Restart on every byte and outside waiting states, else count up.
    always_ff @(posedge clk) begin
        if (!rst_n || !waiting || rx_valid || expire) cnt_q <= '0;
        else                                          cnt_q <= cnt_q + 1'b1;
    end

    assign expire = waiting && !rx_valid && (cnt_q == CW'(TMO_CYC - 1));

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(TMO_CYC)); // R9
endmodule

// File: rtl/pl_buffer.sv
// Packet staging buffer: one write port and one combinational read port.
// Assumes writer and reader never use it in the same cycle.
module pl_buffer #(
    parameter int DEPTH = 256,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    // Store one staged byte.
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/pl_window.sv
// Start address classifier: finalise marker and inclusive window test.
// Assumes LO <= HI.
module pl_window #(
    parameter logic [31:0] LO = 32'h1000_0000,
    parameter logic [31:0] HI = 32'h1FFF_FFFF
) (
    input  logic [31:0] addr,
    output logic        is_final,
    output logic        in_win
);
    // Pure compare, no state.
    always_comb begin
        is_final = &addr;
        in_win   = (addr >= LO) && (addr <= HI);
    end
endmodule

// File: rtl/pkt_load_engine.sv
// Packet loader engine. It parses download and start payloads from the
// shared byte stream, stages the data bytes, commits them after the check
// byte matches, and classifies start addresses.
// Assumes go pulses come from the command responder only while it is idle.
module pkt_load_engine #(
    parameter int          TMO_CYC = 100000,
    parameter logic [31:0] WIN_LO  = 32'h1000_0000,
    parameter logic [31:0] WIN_HI  = 32'h1FFF_FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go_dl,
    input  logic        go_st,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        done,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_special,
    output logic        fin_pulse,
    output logic        jump_req,
    output logic [31:0] jump_addr
);
    import pl_pkg::*;
    localparam int BUF_DEPTH = 1 << PKT_SHIFT;

    pl_state_t            state_q;
    logic [1:0]           cnt_q;
    logic [31:0]          shift_q;   // header or start address
    logic [7:0]           xor_q;
    logic [7:0]           len_q;
    logic [PKT_SHIFT-1:0] idx_q;
    logic                 waiting, expire, is_final, in_win;
    logic                 buf_we;
    logic [7:0]           rx_sum;

    assign waiting = (state_q != S_IDLE) && (state_q != S_WRITE);
    assign rx_sum  = xor_q ^ rx_data;
    assign buf_we  = (state_q == S_DATA) && rx_valid;

    pl_timer #(.TMO_CYC(TMO_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .waiting(waiting),
        .rx_valid(rx_valid), .expire(expire)
    );

    pl_buffer #(.DEPTH(BUF_DEPTH), .DW(8)) u_buf (
        .clk(clk), .we(buf_we), .waddr(idx_q), .wdata(rx_data),
        .raddr(idx_q), .rdata(mem_wdata)
    );

    pl_window #(.LO(WIN_LO), .HI(WIN_HI)) u_win (
        .addr(shift_q), .is_final(is_final), .in_win(in_win)
    );

    // Write port driven straight from the commit state.
    assign mem_we      = (state_q == S_WRITE);
    assign mem_addr    = MA_W'({shift_q[IDX_W-1:0], idx_q});
    assign mem_special = (shift_q[31:24] != 8'h00);
    assign jump_addr   = shift_q;

    // Session sequencer: byte collection, checks, commit and reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            cnt_q     <= '0;
            shift_q   <= '0;
            xor_q     <= '0;
            len_q     <= '0;
            idx_q     <= '0;
            tx_valid  <= 1'b0;
            tx_data   <= '0;
            done      <= 1'b0;
            fin_pulse <= 1'b0;
            jump_req  <= 1'b0;
        end else begin
            tx_valid  <= 1'b0;
            done      <= 1'b0;
            fin_pulse <= 1'b0;
            jump_req  <= 1'b0;
            if (expire) begin
                state_q <= S_IDLE;
                done    <= 1'b1;
            end else begin
                case (state_q)
                    S_IDLE: begin
                        cnt_q <= '0;
                        xor_q <= '0;
                        if (go_dl)      state_q <= S_HDR;
                        else if (go_st) state_q <= S_SADR;
                    end
                    S_HDR, S_SADR: if (rx_valid) begin
                        shift_q <= {shift_q[23:0], rx_data};
                        xor_q   <= rx_sum;
                        cnt_q   <= cnt_q + 1'b1;
                        if (cnt_q == 2'd3)
                            state_q <= (state_q == S_HDR) ? S_HCK : S_SCK;
                    end
                    S_HCK: if (rx_valid) begin
                        tx_valid <= 1'b1;
                        if (rx_sum == 8'h00 && op_allowed(shift_q[31:24])) begin
                            tx_data <= REPLY_ACK;
                            state_q <= S_LEN;
                        end else begin
                            tx_data <= REPLY_NACK;
                            done    <= 1'b1;
                            state_q <= S_IDLE;
                        end
                    end
                    S_LEN: if (rx_valid) begin
                        len_q   <= rx_data;
                        xor_q   <= rx_data;
                        idx_q   <= '0;
                        state_q <= S_DATA;
                    end
                    S_DATA: if (rx_valid) begin
                        xor_q <= rx_sum;
                        if (idx_q == len_q[PKT_SHIFT-1:0]) state_q <= S_DCK;
                        else                               idx_q   <= idx_q + 1'b1;
                    end
                    S_DCK: if (rx_valid) begin
                        idx_q <= '0;
                        if (rx_sum == 8'h00) begin
                            state_q <= S_WRITE;
                        end else begin
                            tx_valid <= 1'b1;
                            tx_data  <= REPLY_NACK;
                            done     <= 1'b1;
                            state_q  <= S_IDLE;
                        end
                    end
                    S_WRITE: begin
                        if (idx_q == len_q[PKT_SHIFT-1:0]) begin
                            tx_valid <= 1'b1;
                            tx_data  <= REPLY_ACK;
                            done     <= 1'b1;
                            state_q  <= S_IDLE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                    S_SCK: if (rx_valid) begin
                        tx_valid <= 1'b1;
                        done     <= 1'b1;
                        state_q  <= S_IDLE;
                        if (rx_sum != 8'h00) begin
                            tx_data <= REPLY_NACK;
                        end else if (is_final) begin
                            tx_data   <= REPLY_ACK;
                            fin_pulse <= 1'b1;
                        end else if (in_win) begin
                            tx_data  <= REPLY_ACK;
                            jump_req <= 1'b1;
                        end else begin
                            tx_data <= REPLY_NACK;
                        end
                    end
                    default: state_q <= S_IDLE;
                endcase
            end
        end
    end

    AST_REPLY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_data == REPLY_ACK || tx_data == REPLY_NACK)); // R2
    AST_WR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 32'd1)); // R5
    AST_DONE_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_we); // R6
    AST_FIN_JUMP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fin_pulse && jump_req)); // R7
    AST_JUMP_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        jump_req |-> (jump_addr >= WIN_LO && jump_addr <= WIN_HI && tx_data == REPLY_ACK)); // R8
    AST_REPLY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_data == REPLY_NACK) |-> done); // R3
endmodule

// File: tb/tb_pkt_load_engine.sv
// Directed bench for the packet loader engine; one task per scenario.
module tb_pkt_load_engine;
    localparam int TMO = 40;
    localparam logic [31:0] LO = 32'h1000_0000;
    localparam logic [31:0] HI = 32'h1FFF_FFFF;

    logic clk = 1'b0, rst_n = 1'b0;
    logic go_dl = 1'b0, go_st = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic tx_valid, done, mem_we, mem_special, fin_pulse, jump_req;
    logic [7:0] tx_data, mem_wdata;
    logic [31:0] mem_addr, jump_addr;

    pkt_load_engine #(.TMO_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .go_dl(go_dl), .go_st(go_st),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid),
        .tx_data(tx_data), .done(done), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_special(mem_special), .fin_pulse(fin_pulse),
        .jump_req(jump_req), .jump_addr(jump_addr)
    );

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0, pcnt = 0;
    int nwr = 0, ntx = 0, ndone = 0, nfin = 0, njump = 0;
    logic [31:0] wa [300];
    logic [7:0]  wd [300];
    logic        ws [300];
    int          wc [300];
    logic [7:0]  txd [8];
    int          txc [8];
    logic [31:0] jlast;

    always @(posedge clk) pcnt <= pcnt + 1;

    // Event logger, sampled away from the active edge.
    always @(negedge clk) if (rst_n) begin
        if (mem_we && nwr < 300) begin
            wa[nwr] = mem_addr; wd[nwr] = mem_wdata; ws[nwr] = mem_special;
            wc[nwr] = pcnt; nwr++;
        end
        if (tx_valid && ntx < 8) begin txd[ntx] = tx_data; txc[ntx] = pcnt; ntx++; end
        if (done) ndone++;
        if (fin_pulse) nfin++;
        if (jump_req) begin njump++; jlast = jump_addr; end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr();
        nwr = 0; ntx = 0; ndone = 0; nfin = 0; njump = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, output int at);
        @(negedge clk); rx_valid = 1'b1; rx_data = b; at = pcnt;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic pulse_dl();
        @(negedge clk); go_dl = 1'b1; @(negedge clk); go_dl = 1'b0;
    endtask

    task automatic pulse_st();
        @(negedge clk); go_st = 1'b1; @(negedge clk); go_st = 1'b0;
    endtask

    // Full download session; expectations derived from R2 to R6 and R9/R10.
    task automatic dl(input logic [7:0] op, input logic [23:0] pkt, input int n,
                      input logic [7:0] seed, input bit bad_h, input bit bad_d,
                      input int gap, input bit poke);
        int at;
        logic [7:0] hx, dx, b;
        bit hdr_ok;
        clr();
        hdr_ok = !bad_h && (op == 8'h00 || op == 8'hF2 || op == 8'hF4);
        pulse_dl();
        send(op, at);
        if (gap > 0) idle(gap - 1);
        send(pkt[23:16], at); send(pkt[15:8], at); send(pkt[7:0], at);
        hx = op ^ pkt[23:16] ^ pkt[15:8] ^ pkt[7:0] ^ (bad_h ? 8'h40 : 8'h00);
        send(hx, at);
        idle(1);
        if (!hdr_ok) begin
            chk(ntx == 1 && txd[0] == 8'h1F, "R3 header refuse code", txd[0], 8'h1F);
            chk(ndone == 1 && nwr == 0, "R3 done and no write", nwr, 0);
            return;
        end
        chk(ntx == 1 && txd[0] == 8'h79 && ndone == 0, "R2 header accept", txd[0], 8'h79);
        chk(txc[0] == at + 1, "R2 header reply cycle", txc[0], at + 1);
        b = 8'(n - 1);
        send(b, at);
        dx = b;
        if (poke) begin
            @(negedge clk); go_dl = 1'b1; go_st = 1'b1;
            @(negedge clk); go_dl = 1'b0; go_st = 1'b0;
        end
        for (int i = 0; i < n; i++) begin
            b = seed + 8'(i * 7);
            dx ^= b;
            send(b, at);
        end
        send(dx ^ (bad_d ? 8'h01 : 8'h00), at);
        idle(n + 3);
        if (bad_d) begin
            chk(nwr == 0, "R4 no write on bad data check", nwr, 0);
            chk(ntx == 2 && txd[1] == 8'h1F && ndone == 1, "R4 refuse code", txd[1], 8'h1F);
            return;
        end
        chk(nwr == n, "R5 write count", nwr, n);
        for (int i = 0; i < n && i < nwr; i++) begin
            b = seed + 8'(i * 7);
            if (wa[i] != {pkt, 8'h00} + 32'(i) || wd[i] != b || ws[i] != (op != 8'h00)) begin
                chk(1'b0, "R5 write content", {wa[i][23:0], wd[i]}, {pkt[15:0] + 16'(0), b});
                break;
            end
        end
        chk(nwr > 0 && wc[0] == at + 1, "R5 first write cycle", wc[0], at + 1);
        chk(ntx == 2 && txd[1] == 8'h79 && txc[1] == wc[nwr-1] + 1, "R6 accept after last write",
            txc[1], wc[nwr-1] + 1);
        chk(ndone == 1 && nfin == 0 && njump == 0, "R10 single done, no start effects", ndone, 1);
        if (op != 8'h00) chk(ws[0] == 1'b1, "R2 special flag", ws[0], 1);
    endtask

    // Start session; expectations derived from R7/R8.
    task automatic st(input logic [31:0] a, input bit bad);
        int at;
        bit ok, fin, jmp;
        clr();
        ok  = !bad;
        fin = ok && (a == 32'hFFFF_FFFF);
        jmp = ok && !fin && a >= LO && a <= HI;
        pulse_st();
        send(a[31:24], at); send(a[23:16], at); send(a[15:8], at); send(a[7:0], at);
        send(a[31:24] ^ a[23:16] ^ a[15:8] ^ a[7:0] ^ (bad ? 8'h80 : 8'h00), at);
        idle(2);
        chk(ntx == 1 && txd[0] == ((fin || jmp) ? 8'h79 : 8'h1F), "R8 start reply code",
            txd[0], (fin || jmp) ? 8'h79 : 8'h1F);
        chk(txc[0] == at + 1 && ndone == 1, "R7 reply cycle with done", txc[0], at + 1);
        chk(nfin == int'(fin), "R7 finalise pulse", nfin, fin);
        chk(njump == int'(jmp), "R8 jump request", njump, jmp);
        if (jmp) chk(jlast == a, "R8 jump address", jlast, a);
    endtask

    task automatic t_reset();
        idle(1);
        chk(!tx_valid && !done && !mem_we && !fin_pulse && !jump_req, "R1 reset outputs",
            {tx_valid, done, mem_we, fin_pulse, jump_req}, 0);
    endtask

    task automatic t_timeout();
        int at;
        dl(8'h00, 24'h000101, 3, 8'h55, 1'b0, 1'b0, TMO - 1, 1'b0);   // R9 last-cycle byte taken
        clr();
        pulse_dl();
        send(8'h00, at);
        idle(TMO - 1);
        send(8'h00, at);   // arrives after expiry, ignored
        idle(4);
        chk(ndone == 1 && ntx == 0 && nwr == 0, "R9 silent abort", {ndone[7:0], ntx[7:0]}, 32'h0100);
        st(32'hFFFF_FFFF, 1'b0);   // engine usable again
    endtask

    task automatic t_ignore();
        int at;
        clr();
        send(8'h31, at); send(8'hCE, at);
        idle(3);
        chk(ntx == 0 && ndone == 0, "R10 idle bytes ignored", ntx, 0);
        dl(8'h00, 24'h000007, 5, 8'h10, 1'b0, 1'b0, 0, 1'b1);           // R10 go during session
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        dl(8'h00, 24'h000003, 4, 8'hA0, 1'b0, 1'b0, 0, 1'b0);
        dl(8'hF2, 24'h123456, 1, 8'h3C, 1'b0, 1'b0, 0, 1'b0);
        dl(8'hF4, 24'hFFFFFF, 256, 8'h01, 1'b0, 1'b0, 0, 1'b0);
        dl(8'hF3, 24'h000001, 4, 8'h00, 1'b0, 1'b0, 0, 1'b0);
        dl(8'h07, 24'h000001, 4, 8'h00, 1'b0, 1'b0, 0, 1'b0);
        dl(8'h00, 24'h000002, 4, 8'h00, 1'b1, 1'b0, 0, 1'b0);
        dl(8'h00, 24'h000004, 9, 8'h77, 1'b0, 1'b1, 0, 1'b0);
        st(32'hFFFF_FFFF, 1'b0);
        st(LO, 1'b0);
        st(HI, 1'b0);
        st(LO - 32'd1, 1'b0);
        st(HI + 32'd1, 1'b0);
        st(32'h1234_5678, 1'b1);
        t_timeout();
        t_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule